// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block turns a fast peripheral clock into the SCL waveform of an I2C master. It drives SCL low for a programmed number of cycles, releases it, waits until the sampled line is really high, and then counts the high phase. A one-cycle tick marks the last cycle of every phase, so a byte sequencer can step its bit counter from it. A second strobe marks the cycle where SDA may change after SCL falls, which gives the bus its data hold time.

Both phases take their length from one configuration word. Each phase lasts its 8-bit divider shifted left by a clamped exponent, plus a fixed offset set at build time. The hold point is a clamped hold code plus three cycles, counted from the first low cycle. The word is captured only when a low phase starts, so software may rewrite it at any time without producing a short or torn phase.

Top module: `i2c_sclgen`

## Requirements
- R1: Each low phase drives `scl_o` to 0 for exactly (LOW_DIV << E) + OFFSET cycles. LOW_DIV is `cfg_word[7:0]` and E is the effective exponent.
- R2: Each high phase counts (HIGH_DIV << E) + OFFSET cycles in which `scl_in` is 1. HIGH_DIV is `cfg_word[15:8]`.
- R3: The exponent field `cfg_word[18:16]` sets E. A code above EXP_MAX is used as EXP_MAX.
- R4: While `scl_o` is released and `scl_in` is 0, the high count pauses and `scl_o` stays 1. A phase stretched by S cycles lasts S cycles longer.
- R5: `sda_chg_o` pulses for one cycle at low-phase cycle index H + 3, where the first low cycle has index 0. H is the effective hold taken from `cfg_word[24:19]`. If H + 3 is not less than the low-phase length, there is no pulse in that phase.
- R6: A hold code above HOLD_MAX is used as HOLD_MAX.
- R7: `tick_o` is 1 for exactly one cycle at the last cycle of each phase, which gives two ticks per SCL period. At the next cycle `scl_o` changes level.
- R8: While `run_en` is 0, `scl_o` is 1 one cycle later and stays there, and neither `tick_o` nor `sda_chg_o` fires. After `run_en` returns to 1, the waveform starts again with a complete low phase.
- R9: The block captures `cfg_word` only when a low phase begins. A write made during a phase affects neither that phase nor the high phase after it. It takes effect from the next low phase.
- R10: While `rst_n` is low, `scl_o` is 1 and `tick_o` and `sda_chg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables waveform generation |
| cfg_word | input | CFG_W (25) | Low divider, high divider, exponent, hold code |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_o | output | 1 | SCL drive level (0 pulls low, 1 releases) |
| tick_o | output | 1 | Last cycle of a phase |
| sda_chg_o | output | 1 | SDA may change in this cycle |

## Verification
The bench builds the block with OFFSET = 3, EXP_MAX = 5 and HOLD_MAX = 20. With these values, exponent codes 6 and 7 and hold codes 21 to 63 become clamp cases that the bench reaches with small dividers. The small offset makes the minimum phase only three cycles long, which is exactly where the hold point falls off the end of the low phase. The bench rewrites the configuration in the second cycle of every period, so the capture point is tested in every period. Random stretch lengths on `scl_in` test the paused high count.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/i2c_sclgen_decode.sv
module i2c_sclgen_decode #(
  parameter int DIV_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 7,
  parameter int HOLD_W   = 6,
  parameter int HOLD_MAX = 63,
  parameter int OFFSET   = 4,
  parameter int CNT_W    = 16,
  localparam int CFG_W   = 2 * DIV_W + EXP_W + HOLD_W
) (
  input  logic [CFG_W-1:0] cfg_word,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] hold_pt
);
  localparam int HI_LSB   = DIV_W;
  localparam int EXP_LSB  = 2 * DIV_W;
  localparam int HOLD_LSB = EXP_LSB + EXP_W;

  // exponent codes beyond the supported range saturate
  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
    return (e > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : e;
  endfunction

  // cycles in one phase: divider scaled by 2^exp, plus the fixed offset
  function automatic logic [CNT_W-1:0] phase_cycles(input logic [DIV_W-1:0] d,
                                                    input logic [EXP_W-1:0] e);
    logic [CNT_W-1:0] wide;
    wide = {{(CNT_W-DIV_W){1'b0}}, d};
    return (wide << e) + CNT_W'(OFFSET);
  endfunction

  // hold point: clamped code plus three cycles
  function automatic logic [CNT_W-1:0] hold_cycles(input logic [HOLD_W-1:0] h);
    logic [HOLD_W-1:0] hc;
    hc = (h > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : h;
    return CNT_W'(hc) + CNT_W'(3);
  endfunction

  logic [EXP_W-1:0] exp_eff;

  always_comb begin
    exp_eff  = clamp_exp(cfg_word[EXP_LSB +: EXP_W]);
    low_len  = phase_cycles(cfg_word[0 +: DIV_W], exp_eff);
    high_len = phase_cycles(cfg_word[HI_LSB +: DIV_W], exp_eff);
    hold_pt  = hold_cycles(cfg_word[HOLD_LSB +: HOLD_W]);
  end
endmodule

// File: rtl/i2c_sclgen_events.sv
module i2c_sclgen_events
  import i2c_sclgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  scl_phase_e       phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] low_len_q,
  input  logic [CNT_W-1:0] high_len_q,
  input  logic [CNT_W-1:0] hold_pt_q,
  input  logic             scl_in,
  output logic             low_end,
  output logic             high_end,
  output logic             scl_o,
  output logic             tick_o,
  output logic             sda_chg_o
);
  always_comb begin
    low_end   = (phase == PH_LOW) && (cnt == low_len_q - CNT_W'(1));
    high_end  = (phase == PH_HIGH) && scl_in && (cnt == high_len_q - CNT_W'(1));
    scl_o     = (phase != PH_LOW);
    tick_o    = low_end || high_end;
    sda_chg_o = (phase == PH_LOW) && (cnt == hold_pt_q);
  end
endmodule

// File: rtl/i2c_sclgen_phase.sv
module i2c_sclgen_phase
  import i2c_sclgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             scl_in,
  input  logic             low_end,
  input  logic             high_end,
  input  logic [CNT_W-1:0] low_len_n,
  input  logic [CNT_W-1:0] high_len_n,
  input  logic [CNT_W-1:0] hold_pt_n,
  output scl_phase_e       phase,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] low_len_q,
  output logic [CNT_W-1:0] high_len_q,
  output logic [CNT_W-1:0] hold_pt_q
);
  logic capture;
  assign capture = run_en && ((phase == PH_IDLE) || high_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q  <= '0;
      high_len_q <= '0;
      hold_pt_q  <= '0;
    end else if (capture) begin
      low_len_q  <= low_len_n;
      high_len_q <= high_len_n;
      hold_pt_q  <= hold_pt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!run_en) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: begin
          if (low_end) begin
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (high_end) begin
            phase <= PH_LOW;
            cnt   <= '0;
          end else if (scl_in) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
  import i2c_sclgen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 7,
  parameter int HOLD_W   = 6,
  parameter int HOLD_MAX = 63,
  parameter int OFFSET   = 4,
  localparam int CFG_W   = 2 * DIV_W + EXP_W + HOLD_W,
  localparam int CNT_W   = DIV_W + (1 << EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             tick_o,
  output logic             sda_chg_o
);
  logic [CNT_W-1:0] low_len_n, high_len_n, hold_pt_n;
  logic [CNT_W-1:0] low_len_q, high_len_q, hold_pt_q;
  logic [CNT_W-1:0] cnt_q;
  scl_phase_e       phase_q;
  logic             low_end, high_end;

  // named views of the phase state for the checker
  logic phase_lo, phase_hi;
  assign phase_lo = (phase_q == PH_LOW);
  assign phase_hi = (phase_q == PH_HIGH);

  i2c_sclgen_decode #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
    .HOLD_W(HOLD_W), .HOLD_MAX(HOLD_MAX), .OFFSET(OFFSET), .CNT_W(CNT_W)
  ) u_decode (
    .cfg_word (cfg_word),
    .low_len  (low_len_n),
    .high_len (high_len_n),
    .hold_pt  (hold_pt_n)
  );

  i2c_sclgen_phase #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .scl_in     (scl_in),
    .low_end    (low_end),
    .high_end   (high_end),
    .low_len_n  (low_len_n),
    .high_len_n (high_len_n),
    .hold_pt_n  (hold_pt_n),
    .phase      (phase_q),
    .cnt        (cnt_q),
    .low_len_q  (low_len_q),
    .high_len_q (high_len_q),
    .hold_pt_q  (hold_pt_q)
  );

  i2c_sclgen_events #(.CNT_W(CNT_W)) u_events (
    .phase      (phase_q),
    .cnt        (cnt_q),
    .low_len_q  (low_len_q),
    .high_len_q (high_len_q),
    .hold_pt_q  (hold_pt_q),
    .scl_in     (scl_in),
    .low_end    (low_end),
    .high_end   (high_end),
    .scl_o      (scl_o),
    .tick_o     (tick_o),
    .sda_chg_o  (sda_chg_o)
  );
endmodule

// File: rtl/i2c_sclgen_chk.sv
module i2c_sclgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             scl_in,
  input logic             scl_o,
  input logic             tick_o,
  input logic             sda_chg_o,
  input logic             phase_lo,
  input logic             phase_hi,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] low_len_q
);
  // R8: disabling releases SCL on the next cycle
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> scl_o);

  // R8: no tick or hold strobe after a disabled cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!tick_o && !sda_chg_o));

  // R4: a stretched high phase does not advance its count
  a_r4_stretch_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_hi && run_en && !scl_in) |=> (cnt == $past(cnt)));

  // R4: SCL stays released for the whole high phase
  a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |-> scl_o);

  // R1: the low counter never reaches the captured length
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_lo |-> (cnt < low_len_q));

  // R9: the captured length holds through a low phase
  a_r9_len_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_lo && $past(phase_lo)) |-> (low_len_q == $past(low_len_q)));

  // R7: every tick is followed by an SCL level change
  a_r7_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_en) |=> (scl_o != $past(scl_o)));

  // R5: the hold strobe falls inside the low phase
  a_r5_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg_o |-> !scl_o);
endmodule

bind i2c_sclgen i2c_sclgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .scl_in    (scl_in),
  .scl_o     (scl_o),
  .tick_o    (tick_o),
  .sda_chg_o (sda_chg_o),
  .phase_lo  (phase_lo),
  .phase_hi  (phase_hi),
  .cnt       (cnt_q),
  .low_len_q (low_len_q)
);

// File: tb/i2c_sclgen_tb.sv
module i2c_sclgen_tb;
  localparam int DIV_W    = 8;
  localparam int EXP_W    = 3;
  localparam int EXP_MAX  = 5;
  localparam int HOLD_W   = 6;
  localparam int HOLD_MAX = 20;
  localparam int OFFSET   = 3;
  localparam int CFG_W    = 2 * DIV_W + EXP_W + HOLD_W;

  logic clk = 1'b0;
  logic rst_n;
  logic run_en;
  logic [CFG_W-1:0] cfg_word;
  logic stretch_act;
  logic scl_in, scl_o, tick_o, sda_chg_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_in = scl_o & ~stretch_act;

  i2c_sclgen #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
    .HOLD_W(HOLD_W), .HOLD_MAX(HOLD_MAX), .OFFSET(OFFSET)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_word(cfg_word),
    .scl_in(scl_in), .scl_o(scl_o), .tick_o(tick_o), .sda_chg_o(sda_chg_o)
  );

  function automatic int e_eff(int e);
    return (e > EXP_MAX) ? EXP_MAX : e;
  endfunction
  function automatic int ph_len(int d, int e);
    return d * (1 << e_eff(e)) + OFFSET;
  endfunction
  function automatic int exp_hold(int h, int lowl);
    int hp;
    hp = ((h > HOLD_MAX) ? HOLD_MAX : h) + 3;
    return (hp < lowl) ? hp : -1;
  endfunction
  function automatic logic [CFG_W-1:0] pack(int lo, int hi, int e, int h);
    logic [CFG_W-1:0] w;
    w = '0;
    w[0 +: DIV_W]             = lo[DIV_W-1:0];
    w[DIV_W +: DIV_W]         = hi[DIV_W-1:0];
    w[2*DIV_W +: EXP_W]       = e[EXP_W-1:0];
    w[2*DIV_W+EXP_W +: HOLD_W] = h[HOLD_W-1:0];
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at the first low-phase sample; ends at the first low sample of the next period.
  task automatic run_period(int stretch, logic [CFG_W-1:0] ncfg,
                            output int lo, output int hi_tot, output int hi_act,
                            output int hidx, output int ticks, output int strobes);
    int s;
    lo = 0; hidx = -1; ticks = 0; strobes = 0; hi_tot = 0; hi_act = 0;
    while (scl_o == 1'b0) begin
      if (sda_chg_o) begin hidx = lo; strobes++; end
      if (tick_o) ticks++;
      if (lo == 1) cfg_word = ncfg;
      lo++;
      @(negedge clk);
    end
    s = stretch;
    while (scl_o == 1'b1) begin
      if (s > 0) begin stretch_act = 1'b1; s--; end
      else stretch_act = 1'b0;
      #1;
      if (tick_o) ticks++;
      if (sda_chg_o) strobes++;
      if (scl_in) hi_act++;
      hi_tot++;
      @(negedge clk);
    end
    stretch_act = 1'b0;
  endtask

  task automatic verify(int lo_d, int hi_d, int e, int h, int stretch, logic [CFG_W-1:0] ncfg);
    int lo, hi_tot, hi_act, hidx, ticks, strobes, ll, hl, eh;
    ll = ph_len(lo_d, e);
    hl = ph_len(hi_d, e);
    eh = exp_hold(h, ll);
    run_period(stretch, ncfg, lo, hi_tot, hi_act, hidx, ticks, strobes);
    // R9: ncfg was written during this period, so lengths are still the old ones
    check((e > EXP_MAX) ? "R1/R3 low length (clamped exp), R9" : "R1 low length, R9", lo, ll);
    check((e > EXP_MAX) ? "R2/R3 high length (clamped exp), R9" : "R2 high length, R9", hi_act, hl);
    check("R4 stretched high duration", hi_tot, hl + stretch);
    check((h > HOLD_MAX) ? "R5/R6 hold index (clamped hold)" : "R5 hold index", hidx, eh);
    check("R5 strobe count", strobes, (eh >= 0) ? 1 : 0);
    check("R7 ticks per period", ticks, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cl, ch, ce, chd, nl, nh, ne, nhd, st;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run_en = 1'b0; stretch_act = 1'b0;
    cfg_word = pack(2, 3, 1, 1);
    repeat (3) @(negedge clk);
    check("R10 scl_o in reset", int'(scl_o), 1);
    check("R10 tick_o in reset", int'(tick_o), 0);
    check("R10 sda_chg_o in reset", int'(sda_chg_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 scl_o idle while disabled", int'(scl_o), 1);
    check("R8 tick_o idle while disabled", int'(tick_o), 0);

    run_en = 1'b1;
    @(negedge clk);
    check("R8 first sample after enable is low", int'(scl_o), 0);
    cl = 2; ch = 3; ce = 1; chd = 1;

    for (int i = 0; i < 24; i++) begin
      case (i)
        0: begin nl = 0;   nh = 0;   ne = 0; nhd = 0;  st = 0; end
        1: begin nl = 5;   nh = 2;   ne = 0; nhd = 30; st = 2; end
        2: begin nl = 4;   nh = 4;   ne = 7; nhd = 9;  st = 0; end
        3: begin nl = 1;   nh = 1;   ne = 2; nhd = 63; st = 5; end
        4: begin nl = 255; nh = 255; ne = 7; nhd = 63; st = 1; end
        5: begin nl = 3;   nh = 2;   ne = 6; nhd = 20; st = 0; end
        default: begin
          nl = int'($urandom_range(15, 0));
          nh = int'($urandom_range(15, 0));
          ne = int'($urandom_range(7, 0));
          nhd = int'($urandom_range(63, 0));
          st = int'($urandom_range(5, 0));
        end
      endcase
      verify(cl, ch, ce, chd, st, pack(nl, nh, ne, nhd));
      cl = nl; ch = nh; ce = ne; chd = nhd;
    end

    // R8: disable in the middle of a low phase, then restart
    repeat (2) @(negedge clk);
    run_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 scl_o released when disabled", int'(scl_o), 1);
      check("R8 no tick when disabled", int'(tick_o), 0);
      check("R8 no strobe when disabled", int'(sda_chg_o), 0);
    end
    cfg_word = pack(2, 1, 0, 0);
    run_en = 1'b1;
    @(negedge clk);
    verify(2, 1, 0, 0, 0, pack(2, 1, 0, 0));
    verify(2, 1, 0, 0, 3, pack(2, 1, 0, 0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule